// File: doc/BRIEF.md
# SPI Master/Slave Serial Controller

This block is a byte-wide SPI controller with a small register interface. One control bit picks master or slave. As a master it generates the serial clock and an active-low select from a 16-bit divisor. It then exchanges one character at a time, and it will not begin the next character until software has both collected the received byte and supplied a new one. As a slave it takes clock, select and data from outside, passes them through synchronizer stages, and acts on clock edges detected in the system clock domain.

Two configuration bits set the clock idle level and the sampling phase. A two-bit direction field turns the engine off, or selects transmit-only, receive-only or full duplex operation. Two status flags report the state of the data registers: transmit holding register empty, and receive register holding unread data. Each flag can raise the interrupt line, and each has its own mask. Sticky status bits record slave underrun and receive overrun.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the status register reads 0x01 (transmit empty only), irq is low, ssnOut is high and sckOut is low.
- R2: Register addresses: 0 data (a write fills the transmit register, a read returns the received byte), 1 control, 2 status, 3 divisor low byte, 4 divisor high byte. Control bits: 0 receive interrupt enable, 1 transmit interrupt enable, [3:2] direction field, 4 clock idle level, 5 phase, 6 master. Status bits: 0 transmit empty, 1 receive full, 2 underrun, 3 overrun, 4 busy. The divisor registers read back what was written.
- R3: A character is 8 bits, most significant bit first. The master drives ssnOut low for the whole character and exchanges sdoOut and sdiIn.
- R4: The idle-level bit sets only the level sckOut rests at. With phase 0 the first bit is on sdoOut as soon as select asserts, data is sampled on the leading clock edge and changed on the trailing edge. With phase 1 data changes on the leading edge and is sampled on the trailing edge.
- R5: In master mode each SCK half-period lasts exactly the divisor value in system clocks. A divisor of 0 counts as 65536.
- R6: In full-duplex master mode no new character begins while the receive byte is unread or the transmit register is empty. Between characters ssnOut stays high and sckOut stays idle.
- R7: Direction field: bit 3 enables transmit and bit 2 enables receive. 00 starts nothing. 10 never sets receive full. 01 sends 0xFF, needs no transmit write to start, and masks the transmit-empty interrupt.
- R8: Writing the data register clears transmit empty. Starting a character that uses the transmit byte sets it again. Completing a received character sets receive full, and reading the data register clears it.
- R9: irq is high exactly when transmit empty is set with its enable and transmit direction on, or receive full is set with its enable.
- R10: In slave mode the block exchanges one character per select-low frame, with sckIn, ssnIn and sdiIn synchronized, for SCK up to one-eighth of the system clock.
- R11: If a slave character starts while the transmit register is empty, the previous byte is sent again and the underrun bit is set.
- R12: A character that completes while receive full is still set sets the overrun bit and leaves the stored byte unchanged. Writing 1 to status bit 2 or 3 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (data reads have a side effect) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Serial clock driven in master mode |
| ssnOut | output | 1 | Active-low select driven in master mode |
| sdoOut | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sckIn | input | 1 | Serial clock from an external master |
| ssnIn | input | 1 | Active-low select from an external master |
| sdiIn | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The bench targets the master stall. A design that launched a character as soon as a byte was written, before the received byte was read, would pull ssnOut low while the bench checks it cycle by cycle. It times the first clock edge after select with divisors 3 and 0, which catches an off-by-one counter or a zero divisor that wraps to the fastest rate instead of the slowest. In slave mode it leaves the transmit register empty and then leaves a received byte unread. A wrong design would either send stale or garbage data without flagging underrun, or overwrite the held byte instead of keeping it and raising overrun. It also checks both phase settings in each mode, where a swapped sample edge shows up as a byte shifted by one bit.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

  typedef struct packed {
    logic load;      // begin a character
    logic present;   // put first bit on the line at load (phase 0)
    logic shiftOut;  // advance transmit data
    logic sampleIn;  // capture one received bit
    logic finish;    // character complete
  } engStrobe_t;

  typedef struct packed {
    logic       master;
    logic       phase;
    logic       clkPol;
    logic [1:0] enSel;   // [1] transmit, [0] receive
    logic       txIe;
    logic       rxIe;
  } ctlCfg_t;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_DIVL = 3'd3;
  localparam logic [2:0] ADDR_DIVH = 3'd4;

endpackage

// File: rtl/spi_ctrl_ctl.sv
module spi_ctrl_ctl
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              sckIn,
  input  logic              ssnIn,
  input  logic              sdiIn,
  output ctlCfg_t           cfg,
  output logic [DIV_W-1:0]  divisor,
  output engStrobe_t        stb,
  output logic              sdiBit,
  output logic              sckOut,
  output logic              ssnOut,
  output logic              busy
);
  localparam int CNT_W  = DIV_W + 1;
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam int SCNT_W = $clog2(DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      divisor <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) cfg <= ctlCfg_t'(wrData[6:0]);
      if (addr == ADDR_DIVL) divisor[7:0] <= wrData[7:0];
      if (addr == ADDR_DIVH) divisor[DIV_W-1:8] <= wrData[DIV_W-9:0];
    end
  end

  // ---------------- master sequencer ----------------
  logic [CNT_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              mActive, sckTog;
  logic [CNT_W-1:0]  divEff;
  logic              mTick, mEdge, mLead, startOk;

  assign divEff  = (divisor == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, divisor};
  assign mTick   = mActive && (divCnt == divEff - CNT_W'(1));
  assign mEdge   = mTick && (edgeCnt != LAST_EDGE);
  assign mLead   = ~edgeCnt[0];
  assign startOk = cfg.master && (cfg.enSel != 2'b00) && !mActive &&
                   (!cfg.enSel[1] || !txEmpty) && (!cfg.enSel[0] || !rxFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckTog  <= 1'b0;
    end else if (!mActive) begin
      if (startOk) begin
        mActive <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
        sckTog  <= 1'b0;
      end
    end else if (mTick) begin
      divCnt <= '0;
      if (edgeCnt == LAST_EDGE) mActive <= 1'b0;
      else begin
        sckTog  <= ~sckTog;
        edgeCnt <= edgeCnt + EDGE_W'(1);
      end
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  // ---------------- slave synchronizer and edge detect ----------------
  logic [SYNC_STAGES-1:0] sckSync, ssnSync, sdiSync;
  logic                   sckPrev, ssnPrev, sActive;
  logic [SCNT_W-1:0]      sCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      ssnSync <= '1;
      sdiSync <= '0;
      sckPrev <= 1'b0;
      ssnPrev <= 1'b1;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      ssnSync <= {ssnSync[SYNC_STAGES-2:0], ssnIn};
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdiIn};
      sckPrev <= sckSync[SYNC_STAGES-1];
      ssnPrev <= ssnSync[SYNC_STAGES-1];
    end
  end

  logic slaveOn, ssnS, sLoad, sEdge, sLead, sSample, sShift, sFinish;
  assign slaveOn = !cfg.master && (cfg.enSel != 2'b00);
  assign ssnS    = ssnSync[SYNC_STAGES-1];
  assign sLoad   = slaveOn && ssnPrev && !ssnS;
  assign sEdge   = slaveOn && sActive && !ssnS && (sckSync[SYNC_STAGES-1] != sckPrev);
  assign sLead   = sckSync[SYNC_STAGES-1] ^ cfg.clkPol;
  assign sSample = sEdge && (cfg.phase ? !sLead : sLead);
  assign sShift  = sEdge && (cfg.phase ? sLead : !sLead);
  assign sFinish = sSample && (sCnt == SCNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sActive <= 1'b0;
      sCnt    <= '0;
    end else if (sLoad) begin
      sActive <= 1'b1;
      sCnt    <= '0;
    end else if (sFinish || ssnS) begin
      sActive <= 1'b0;
    end else if (sSample) begin
      sCnt <= sCnt + SCNT_W'(1);
    end
  end

  // ---------------- strobe selection ----------------
  always_comb begin
    if (cfg.master) begin
      stb.load     = startOk;
      stb.present  = startOk && !cfg.phase;
      stb.shiftOut = mEdge && (cfg.phase ? mLead : !mLead);
      stb.sampleIn = mEdge && (cfg.phase ? !mLead : mLead);
      stb.finish   = mTick && (edgeCnt == LAST_EDGE);
    end else begin
      stb.load     = sLoad;
      stb.present  = sLoad && !cfg.phase;
      stb.shiftOut = sShift;
      stb.sampleIn = sSample;
      stb.finish   = sFinish;
    end
  end

  assign sdiBit = cfg.master ? sdiIn : sdiSync[SYNC_STAGES-1];
  assign sckOut = (cfg.master && mActive) ? (sckTog ^ cfg.clkPol) : cfg.clkPol;
  assign ssnOut = !(cfg.master && mActive);
  assign busy   = mActive || sActive;

endmodule

// File: rtl/spi_ctrl_dp.sv
module spi_ctrl_dp
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        enSel,
  input  logic              txIe,
  input  logic              rxIe,
  input  engStrobe_t        stb,
  input  logic              sdiBit,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              underrun,
  output logic              overrun,
  output logic [DATA_W-1:0] rxData,
  output logic              sdoOut,
  output logic              irq
);
  logic [DATA_W-1:0] txBuf, txShift, rxShift, loadVal, rxNext, rxPick;
  logic              sdoReg, dataWr, dataRd, statWr, rxCapture;

  assign dataWr    = wrEn && (addr == ADDR_DATA);
  assign dataRd    = rdEn && (addr == ADDR_DATA);
  assign statWr    = wrEn && (addr == ADDR_STAT);
  assign loadVal   = enSel[1] ? txBuf : '1;
  assign rxNext    = {rxShift[DATA_W-2:0], sdiBit};
  assign rxPick    = stb.sampleIn ? rxNext : rxShift;
  assign rxCapture = stb.finish && enSel[0];

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      txEmpty  <= 1'b1;
      underrun <= 1'b0;
      txShift  <= '1;
      sdoReg   <= 1'b1;
    end else begin
      if (dataWr) txBuf <= wrData;

      if (dataWr)                      txEmpty <= 1'b0;
      else if (stb.load && enSel[1])   txEmpty <= 1'b1;

      if (stb.load && enSel[1] && txEmpty) underrun <= 1'b1;
      else if (statWr && wrData[2])        underrun <= 1'b0;

      if (stb.load) begin
        if (stb.present) begin
          sdoReg  <= loadVal[DATA_W-1];
          txShift <= {loadVal[DATA_W-2:0], 1'b1};
        end else begin
          txShift <= loadVal;
        end
      end else if (stb.shiftOut) begin
        sdoReg  <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b1};
      end
    end
  end

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.load)          rxShift <= '0;
      else if (stb.sampleIn) rxShift <= rxNext;

      if (rxCapture) begin
        if (rxFull && !dataRd) overrun <= 1'b1;
        else begin
          rxData <= rxPick;
          rxFull <= 1'b1;
        end
      end else if (dataRd) begin
        rxFull <= 1'b0;
      end

      if (statWr && wrData[3] && !(rxCapture && rxFull && !dataRd)) overrun <= 1'b0;
    end
  end

  assign sdoOut = sdoReg;
  assign irq    = (txEmpty && txIe && enSel[1]) || (rxFull && rxIe);

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              sckOut,
  output logic              ssnOut,
  output logic              sdoOut,
  input  logic              sckIn,
  input  logic              ssnIn,
  input  logic              sdiIn
);
  ctlCfg_t           cfgW;
  engStrobe_t        stbW;
  logic [DIV_W-1:0]  divW;
  logic [DATA_W-1:0] rxDataW;
  logic              txEmptyW, rxFullW, underrunW, overrunW, busyW, sdiBitW;

  spi_ctrl_ctl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .txEmpty(txEmptyW), .rxFull(rxFullW),
    .sckIn(sckIn), .ssnIn(ssnIn), .sdiIn(sdiIn),
    .cfg(cfgW), .divisor(divW), .stb(stbW), .sdiBit(sdiBitW),
    .sckOut(sckOut), .ssnOut(ssnOut), .busy(busyW)
  );

  spi_ctrl_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .enSel(cfgW.enSel), .txIe(cfgW.txIe), .rxIe(cfgW.rxIe),
    .stb(stbW), .sdiBit(sdiBitW),
    .txEmpty(txEmptyW), .rxFull(rxFullW), .underrun(underrunW), .overrun(overrunW),
    .rxData(rxDataW), .sdoOut(sdoOut), .irq(irq)
  );

  always_comb begin
    case (addr)
      ADDR_DATA: rdData = rxDataW;
      ADDR_CTRL: rdData = {{(DATA_W-7){1'b0}}, cfgW};
      ADDR_STAT: rdData = {{(DATA_W-5){1'b0}}, busyW, overrunW, underrunW, rxFullW, txEmptyW};
      ADDR_DIVL: rdData = divW[7:0];
      ADDR_DIVH: rdData = DATA_W'(divW[DIV_W-1:8]);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              master,
  input logic              clkPol,
  input logic [1:0]        enSel,
  input logic              txIe,
  input logic              rxIe,
  input logic              rxFull,
  input logic              overrun,
  input logic [DATA_W-1:0] rxData,
  input logic              sckOut,
  input logic              ssnOut,
  input logic              irq
);
  // idle clock level only moves when the polarity setting moves
  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ssnOut && $past(ssnOut) && $stable(clkPol)) |-> $stable(sckOut));

  // no new character while an unread byte is held in full duplex master mode
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (master && enSel == 2'b11 && rxFull && ssnOut) |=> ssnOut);

  // transmit-only never sets the receive flag
  assert_txonly_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enSel == 2'b10 && $past(enSel) == 2'b10 && !$past(rxFull)) |-> !rxFull);

  // both interrupt sources masked means no request
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!txIe && !rxIe) |-> !irq);

  // overrun keeps the held byte
  assert_overrun_keep_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && $past(rxFull) && $rose(overrun)) |-> $stable(rxData));
endmodule

bind spi_ctrl spi_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .master(cfgW.master), .clkPol(cfgW.clkPol),
  .enSel(cfgW.enSel), .txIe(cfgW.txIe), .rxIe(cfgW.rxIe), .rxFull(rxFullW),
  .overrun(overrunW), .rxData(rxDataW), .sckOut(sckOut), .ssnOut(ssnOut), .irq(irq)
);

// File: tb/sim_spi_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq, sckOut, ssnOut, sdoOut;
  logic       sckIn = 1'b0, ssnIn = 1'b1;
  logic       slaveTest = 1'b0, drvSdi = 1'b0, devSdi = 1'b0;
  logic       sdiIn;
  int         nChecks = 0, nErr = 0;
  bit         done = 1'b0;

  assign sdiIn = slaveTest ? drvSdi : devSdi;

  always #4 clk = ~clk;

  spi_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .sckOut(sckOut), .ssnOut(ssnOut), .sdoOut(sdoOut),
    .sckIn(sckIn), .ssnIn(ssnIn), .sdiIn(sdiIn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // behavioural slave device for master-mode runs
  logic       devPhase = 1'b0, devPol = 1'b0;
  logic [7:0] devTx = '0, devRx = '0, devShift = '0;
  logic       prevSck = 1'b0, prevSsn = 1'b1;
  always @(negedge clk) begin
    if (prevSsn && !ssnOut) begin
      devShift = devTx; devRx = '0;
      if (!devPhase) begin devSdi = devShift[7]; devShift = {devShift[6:0], 1'b1}; end
    end else if (!ssnOut && sckOut !== prevSck) begin
      if (devPhase ? !(sckOut ^ devPol) : (sckOut ^ devPol))
        devRx = {devRx[6:0], sdoOut};
      else begin devSdi = devShift[7]; devShift = {devShift[6:0], 1'b1}; end
    end
    prevSck = sckOut; prevSsn = ssnOut;
  end

  // per-clock reference of the idle pins while the bench expects no character
  logic idleMon = 1'b0, idlePol = 1'b0;
  always @(negedge clk) if (idleMon) begin
    chk("R6 ssnOut idle", ssnOut, 1);
    chk("R6 sckOut idle", sckOut, idlePol);
  end

  task automatic waitXfer();
    int n;
    n = 0;
    while (ssnOut === 1'b1 && n < 3000) begin @(negedge clk); n++; end
    n = 0;
    while (ssnOut === 1'b0 && n < 3000) begin @(negedge clk); n++; end
    if (ssnOut !== 1'b1) chk("R3 transfer end", ssnOut, 1);
  endtask

  task automatic slaveXfer(input logic ph, input logic pol, input logic [7:0] tx,
                           output logic [7:0] r);
    r = '0;
    @(negedge clk); ssnIn = 1'b0;
    if (!ph) drvSdi = tx[7];
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sckIn = ~pol;
      if (!ph) r[7-i] = sdoOut; else drvSdi = tx[7-i];
      repeat (8) @(negedge clk);
      sckIn = pol;
      if (!ph) begin if (i < 7) drvSdi = tx[6-i]; end
      else r[7-i] = sdoOut;
      repeat (8) @(negedge clk);
    end
    ssnIn = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, r;
    int n;
    repeat (3) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRead(3'd2, d); chk("R1 status", d, 8'h01);
    chk("R1 irq", irq, 0); chk("R1 ssnOut", ssnOut, 1); chk("R1 sckOut", sckOut, 0);

    // R2 divisor readback
    regWrite(3'd4, 8'h12); regRead(3'd4, d); chk("R2 divisor high", d, 8'h12);
    regWrite(3'd4, 8'h00); regWrite(3'd3, 8'h01);
    regRead(3'd3, d); chk("R2 divisor low", d, 8'h01);

    // R9 transmit interrupt and its mask (transmit empty, nothing to send)
    regWrite(3'd1, 8'h4E); @(negedge clk); chk("R9 tx irq on", irq, 1);
    regRead(3'd1, d); chk("R2 control readback", d, 8'h4E);
    regWrite(3'd1, 8'h4C); @(negedge clk); chk("R9 tx irq masked", irq, 0);
    chk("R6 no start without tx byte", ssnOut, 1);

    // R3 master full duplex, phase 0, idle low, divisor 1
    regWrite(3'd1, 8'h4D);
    devPhase = 0; devPol = 0; devTx = 8'h3C;
    regWrite(3'd0, 8'hA5); waitXfer();
    chk("R3 device received", devRx, 8'hA5);
    regRead(3'd2, d); chk("R8 flags after char", d, 8'h03);
    chk("R9 rx irq", irq, 1);
    regRead(3'd0, d); chk("R3 master received", d, 8'h3C);
    regRead(3'd2, d); chk("R8 rx cleared by read", d, 8'h01);

    // R6 stall: second char, then write without reading
    devTx = 8'hC3; regWrite(3'd0, 8'h5A); waitXfer();
    chk("R3 device received 2", devRx, 8'h5A);
    regWrite(3'd0, 8'h77);
    idlePol = 0; idleMon = 1;
    repeat (60) @(negedge clk);
    idleMon = 0;
    devTx = 8'h81;
    regRead(3'd0, d); chk("R6 held byte", d, 8'hC3);
    waitXfer(); chk("R6 resumes after read", devRx, 8'h77);
    regRead(3'd0, d); chk("R3 master received 3", d, 8'h81);

    // R4 R5 phase 1, idle high, divisor 3
    regWrite(3'd3, 8'h03); regWrite(3'd1, 8'h7D);
    repeat (2) @(negedge clk); chk("R4 idle high", sckOut, 1);
    devPhase = 1; devPol = 1; devTx = 8'h39;
    regWrite(3'd0, 8'hC6);
    n = 0; while (ssnOut === 1'b1 && n < 100) begin @(negedge clk); n++; end
    n = 0; while (sckOut === 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk("R5 half period 3", n, 3);
    waitXfer();
    chk("R4 phase1 device received", devRx, 8'hC6);
    regRead(3'd0, d); chk("R4 phase1 master received", d, 8'h39);

    // R7 transmit-only
    regWrite(3'd3, 8'h02); regWrite(3'd1, 8'h48);
    devPhase = 0; devPol = 0; devTx = 8'hFF;
    regWrite(3'd0, 8'h3A); waitXfer();
    chk("R7 tx-only sent", devRx, 8'h3A);
    regRead(3'd2, d); chk("R7 tx-only no rx flag", d, 8'h01);

    // R7 receive-only: starts without a write, sends ones
    devTx = 8'h6E; regWrite(3'd1, 8'h44); waitXfer();
    chk("R7 rx-only sends ones", devRx, 8'hFF);
    regRead(3'd0, d); chk("R7 rx-only received", d, 8'h6E);
    regWrite(3'd1, 8'h40);
    n = 0; while (ssnOut === 1'b0 && n < 200) begin @(negedge clk); n++; end

    // R7 disabled: a written byte does not start a character
    regWrite(3'd0, 8'h55);
    idlePol = 0; idleMon = 1; repeat (40) @(negedge clk); idleMon = 0;
    chk("R7 disabled stays idle", ssnOut, 1);

    // R5 divisor zero means 65536
    pulseReset();
    regWrite(3'd3, 8'h00); regWrite(3'd4, 8'h00); regWrite(3'd1, 8'h4C);
    regWrite(3'd0, 8'h01);
    n = 0; while (ssnOut === 1'b1 && n < 100) begin @(negedge clk); n++; end
    n = 0; while (sckOut === 1'b0 && n < 70000) begin @(negedge clk); n++; end
    chk("R5 divisor zero", n, 65536);
    pulseReset();

    // R10 slave phase 0
    slaveTest = 1; sckIn = 0;
    regWrite(3'd1, 8'h0C); regWrite(3'd0, 8'h4B);
    slaveXfer(1'b0, 1'b0, 8'h96, r);
    chk("R10 slave sent", r, 8'h4B);
    regRead(3'd2, d); chk("R8 slave flags", d, 8'h03);
    regRead(3'd0, d); chk("R10 slave received", d, 8'h96);

    // R11 underrun: nothing written, previous byte repeats
    slaveXfer(1'b0, 1'b0, 8'h21, r);
    chk("R11 repeat last byte", r, 8'h4B);
    regRead(3'd2, d); chk("R11 underrun flag", d, 8'h07);

    // R12 overrun keeps old byte, then write-one-to-clear
    slaveXfer(1'b0, 1'b0, 8'h33, r);
    regRead(3'd2, d); chk("R12 overrun flag", d, 8'h0F);
    regRead(3'd0, d); chk("R12 old byte kept", d, 8'h21);
    regWrite(3'd2, 8'h0C);
    regRead(3'd2, d); chk("R12 sticky bits cleared", d, 8'h01);

    // R10 R4 slave phase 1, idle high
    sckIn = 1; repeat (4) @(negedge clk);
    regWrite(3'd1, 8'h3C); regWrite(3'd0, 8'hE1);
    slaveXfer(1'b1, 1'b1, 8'h7D, r);
    chk("R10 slave phase1 sent", r, 8'hE1);
    regRead(3'd0, d); chk("R10 slave phase1 received", d, 8'h7D);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule